// File: doc/BRIEF.md
# Spindle Motor Start-Up Sequencer

This block is the digital sequencer for a three-phase sensorless spindle motor driver. It decides which phase is pulled high, which is pulled low and which floats, and walks the motor through spin detection, alignment, commutation, energy recovery and braking. The inputs are a driver enable, a run/brake command, a one-step advance pulse from a host, a back-EMF zero-crossing strobe and a speed-reached flag. The zero-crossing strobe is a one-cycle pulse produced by an external comparator. The speed-reached flag comes from an external speed regulator.

When the run command goes high, the sequencer first watches for zero crossings to learn whether the spindle is still turning. If it sees one, it joins the rotation directly. If the window passes with no crossing, it aligns the rotor at one step for a fixed time and then jumps two steps forward before it starts commutating. During start-up and run, each zero crossing advances the commutation one step after a mask delay. A host can also advance the step itself with the increment pulse. When the run command falls, the drivers float for a programmable recovery time, and then all low-side switches are turned on to brake the motor.

Top module: `spindle_seq`

## Requirements
- R1: While reset is held, mode_o is 0 (idle), step_o is 1, hs_o and ls_o are 000, tri_o is 1 and spin_o is 0.
- R2: While oe_i is low, hs_o and ls_o are 000 and tri_o is 1 in every mode, including brake.
- R3: While run_i is low in idle, the mode stays 0 and the step stays 1. When run_i is high in idle, park or brake, the next edge sets mode 1 (spin check) and step 2. All drivers stay off during spin check.
- R4: The spin-check window counts only the cycles in which oe_i is high. After 2^SPIN_W counted cycles with no zero crossing, the mode becomes 2 (align).
- R5: A zero crossing seen in spin check while oe_i is high moves the mode to 3 (start-up) at the next edge. The step stays at 2, so alignment is skipped.
- R6: In align, the outputs drive the current step. After ALIGN_DIV*ALIGN_TICKS cycles the step advances by two (step 2 becomes step 4) and the mode becomes 3.
- R7: Phase bit 0 is A, bit 1 is B and bit 2 is C. The steps drive as follows: step 1 is A high, B low; step 2 is A high, C low; step 3 is B high, C low; step 4 is B high, A low; step 5 is C high, A low; step 6 is C high, B low. No phase is ever driven high and low at once.
- R8: A one-cycle pulse on seq_inc_i in modes 2, 3 or 4 advances the step by one at the next edge, and step 6 wraps to step 1.
- R9: In modes 3 and 4, a zero crossing advances the step by one exactly MASK_CYC edges after the edge that captured it. A further crossing that arrives while that delay is pending is ignored.
- R10: In mode 3 with run_i high, speed_ok_i high moves the mode to 4 (run) at the next edge.
- R11: When run_i is low in modes 1 to 4, the next edge enters mode 5 (park) with step 1 and all drivers off. After (brk_dly_i+1)*PARK_UNIT cycles the mode becomes 6 (brake), with ls_o = 111 and hs_o = 000 while oe_i is high.
- R12: spin_o toggles at every edge where zc_i is high, whatever the mode.
- R13: tri_o is 1 exactly when no bit of hs_o or ls_o is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oe_i | input | 1 | Power driver enable; low floats every phase |
| run_i | input | 1 | High runs the motor, low parks then brakes |
| seq_inc_i | input | 1 | One-cycle pulse that advances the step by one |
| zc_i | input | 1 | One-cycle back-EMF zero-crossing strobe |
| speed_ok_i | input | 1 | Nominal speed reached |
| brk_dly_i | input | BRK_W | Park duration, in units of PARK_UNIT cycles, minus one |
| hs_o | output | 3 | High-side enables, bit 0 = phase A |
| ls_o | output | 3 | Low-side enables, bit 0 = phase A |
| tri_o | output | 1 | All drivers off |
| mode_o | output | 3 | 0 idle, 1 spin check, 2 align, 3 start-up, 4 run, 5 park, 6 brake |
| step_o | output | 3 | Commutation step, 1 to 6 |
| spin_o | output | 1 | Toggles on each zero crossing |

## Verification
The commutation decode is driven with increment pulses through all six steps, and the walk crosses the wrap from step 6 to step 1. A wrong table entry, a drive on both sides of one phase, or a missed wrap each shows up at a separate vector. Start-up is run twice. A silent spin-check window must lead through alignment and the two-step jump. A crossing inside the window must skip alignment and keep step 2. A run without the enable and the zero-crossing mask delay are timed to the edge, and a second crossing is sent during the mask to show it has no effect. Shutdown uses a non-zero brake delay so that the park length and the all-low brake pattern can both be checked, and the enable is then dropped to show that it overrides the brake.

// File: rtl/spin_pkg.sv
package spin_pkg;

   typedef enum logic [2:0] {
      M_IDLE  = 3'd0,
      M_CHECK = 3'd1,
      M_ALIGN = 3'd2,
      M_START = 3'd3,
      M_RUN   = 3'd4,
      M_PARK  = 3'd5,
      M_BRAKE = 3'd6
   } mode_e;

   typedef logic [2:0] step_t;

   // advance a 1..6 commutation step by n (n <= 6), wrapping after 6
   function automatic step_t step_add(input step_t s, input logic [2:0] n);
      logic [3:0] t;
      t = {1'b0, s} + {1'b0, n};
      return (t > 4'd6) ? step_t'(t - 4'd6) : step_t'(t);
   endfunction

endpackage

// File: rtl/spin_step_decode.sv
module spin_step_decode
   import spin_pkg::*;
(
   input  step_t      step_i,
   output logic [2:0] hi_o,
   output logic [2:0] lo_o
);

   for (genvar p = 0; p < 3; p++) begin : g_phase
      localparam step_t HI_A = step_t'(2 * p + 1);
      localparam step_t HI_B = step_t'(2 * p + 2);
      localparam step_t LO_A = step_t'(((2 * p + 3) % 6) + 1);
      localparam step_t LO_B = step_t'(((2 * p + 4) % 6) + 1);
      assign hi_o[p] = (step_i == HI_A) || (step_i == HI_B);
      assign lo_o[p] = (step_i == LO_A) || (step_i == LO_B);
   end

endmodule

// File: rtl/spin_zc_delay.sv
module spin_zc_delay #(
   parameter int MASK_CYC = 5
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic arm_i,
   input  logic zc_i,
   output logic adv_o
);

   localparam int CW = $clog2(MASK_CYC + 1);
   localparam logic [CW-1:0] LOAD = CW'(MASK_CYC);

   if (MASK_CYC < 1) begin : g_bad_mask
      $error("spin_zc_delay: MASK_CYC must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (!arm_i)          cnt_q <= '0;
      else if (cnt_q == '0) begin
         if (zc_i)              cnt_q <= LOAD;
      end else                  cnt_q <= cnt_q - 1'b1;
   end

   assign adv_o = arm_i && (cnt_q == CW'(1));

endmodule

// File: rtl/spin_mode_fsm.sv
module spin_mode_fsm
   import spin_pkg::*;
#(
   parameter int SPIN_W      = 4,
   parameter int ALIGN_DIV   = 4,
   parameter int ALIGN_TICKS = 64,
   parameter int BRK_W       = 3,
   parameter int PARK_UNIT   = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             oe_i,
   input  logic             zc_i,
   input  logic             inc_i,
   input  logic             adv_i,
   input  logic             speed_i,
   input  logic [BRK_W-1:0] brk_dly_i,
   output mode_e            mode_o,
   output step_t            step_o
);

   localparam int WIN       = 1 << SPIN_W;
   localparam int ALIGN_LEN = ALIGN_DIV * ALIGN_TICKS;
   localparam int PARK_MAX  = (1 << BRK_W) * PARK_UNIT;
   localparam int LMAX1     = (WIN > ALIGN_LEN) ? WIN : ALIGN_LEN;
   localparam int LMAX      = (LMAX1 > PARK_MAX) ? LMAX1 : PARK_MAX;
   localparam int CNT_W     = $clog2(LMAX + 1);
   localparam logic [CNT_W-1:0] WIN_LAST   = CNT_W'(WIN - 1);
   localparam logic [CNT_W-1:0] ALIGN_LAST = CNT_W'(ALIGN_LEN - 1);

   if (SPIN_W < 1 || ALIGN_DIV < 1 || ALIGN_TICKS < 1 || BRK_W < 1 || PARK_UNIT < 1)
   begin : g_bad_cfg
      $error("spin_mode_fsm: every timing parameter must be at least 1");
   end

   mode_e            mode_q;
   step_t            step_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] park_last;

   assign park_last = CNT_W'((int'(brk_dly_i) + 1) * PARK_UNIT - 1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q <= M_IDLE;
         step_q <= 3'd1;
         cnt_q  <= '0;
      end else begin
         case (mode_q)
            M_IDLE, M_BRAKE: begin
               step_q <= 3'd1;
               cnt_q  <= '0;
               if (run_i) begin
                  mode_q <= M_CHECK;
                  step_q <= 3'd2;
               end
            end
            M_PARK: begin
               if (run_i) begin
                  mode_q <= M_CHECK;
                  step_q <= 3'd2;
                  cnt_q  <= '0;
               end else if (cnt_q == park_last) begin
                  mode_q <= M_BRAKE;
                  cnt_q  <= '0;
               end else begin
                  cnt_q  <= cnt_q + 1'b1;
               end
            end
            M_CHECK: begin
               if (!run_i) begin
                  mode_q <= M_PARK;
                  step_q <= 3'd1;
                  cnt_q  <= '0;
               end else if (oe_i) begin
                  if (zc_i) begin
                     mode_q <= M_START;
                     cnt_q  <= '0;
                  end else if (cnt_q == WIN_LAST) begin
                     mode_q <= M_ALIGN;
                     cnt_q  <= '0;
                  end else begin
                     cnt_q  <= cnt_q + 1'b1;
                  end
               end
            end
            M_ALIGN: begin
               if (!run_i) begin
                  mode_q <= M_PARK;
                  step_q <= 3'd1;
                  cnt_q  <= '0;
               end else if (cnt_q == ALIGN_LAST) begin
                  mode_q <= M_START;
                  step_q <= step_add(step_q, 3'd2);
                  cnt_q  <= '0;
               end else begin
                  cnt_q  <= cnt_q + 1'b1;
                  if (inc_i) step_q <= step_add(step_q, 3'd1);
               end
            end
            M_START, M_RUN: begin
               if (!run_i) begin
                  mode_q <= M_PARK;
                  step_q <= 3'd1;
                  cnt_q  <= '0;
               end else begin
                  if (mode_q == M_START && speed_i) mode_q <= M_RUN;
                  if (inc_i || adv_i) step_q <= step_add(step_q, 3'd1);
               end
            end
            default: begin
               mode_q <= M_IDLE;
               step_q <= 3'd1;
               cnt_q  <= '0;
            end
         endcase
      end
   end

   assign mode_o = mode_q;
   assign step_o = step_q;

endmodule

// File: rtl/spindle_seq.sv
module spindle_seq
   import spin_pkg::*;
#(
   parameter int SPIN_W      = 4,
   parameter int ALIGN_DIV   = 4,
   parameter int ALIGN_TICKS = 64,
   parameter int MASK_CYC    = 5,
   parameter int BRK_W       = 3,
   parameter int PARK_UNIT   = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             oe_i,
   input  logic             run_i,
   input  logic             seq_inc_i,
   input  logic             zc_i,
   input  logic             speed_ok_i,
   input  logic [BRK_W-1:0] brk_dly_i,
   output logic [2:0]       hs_o,
   output logic [2:0]       ls_o,
   output logic             tri_o,
   output logic [2:0]       mode_o,
   output logic [2:0]       step_o,
   output logic             spin_o
);

   mode_e      mode;
   step_t      step;
   logic       adv;
   logic       armed;
   logic       drive_on;
   logic [2:0] tbl_hi;
   logic [2:0] tbl_lo;
   logic       spin_q;

   assign armed    = (mode == M_START) || (mode == M_RUN);
   assign drive_on = armed || (mode == M_ALIGN);

   spin_mode_fsm #(
      .SPIN_W      (SPIN_W),
      .ALIGN_DIV   (ALIGN_DIV),
      .ALIGN_TICKS (ALIGN_TICKS),
      .BRK_W       (BRK_W),
      .PARK_UNIT   (PARK_UNIT)
   ) u_fsm (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run_i),
      .oe_i      (oe_i),
      .zc_i      (zc_i),
      .inc_i     (seq_inc_i),
      .adv_i     (adv),
      .speed_i   (speed_ok_i),
      .brk_dly_i (brk_dly_i),
      .mode_o    (mode),
      .step_o    (step)
   );

   spin_zc_delay #(.MASK_CYC(MASK_CYC)) u_zcd (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .arm_i  (armed),
      .zc_i   (zc_i),
      .adv_o  (adv)
   );

   spin_step_decode u_dec (
      .step_i (step),
      .hi_o   (tbl_hi),
      .lo_o   (tbl_lo)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) spin_q <= 1'b0;
      else         spin_q <= spin_q ^ zc_i;
   end

   always_comb begin
      hs_o = '0;
      ls_o = '0;
      if (oe_i) begin
         if (drive_on) begin
            hs_o = tbl_hi;
            ls_o = tbl_lo;
         end else if (mode == M_BRAKE) begin
            ls_o = '1;
         end
      end
   end

   assign tri_o  = ~|{hs_o, ls_o};
   assign mode_o = mode;
   assign step_o = step;
   assign spin_o = spin_q;

endmodule

// File: rtl/spindle_seq_chk.sv
module spindle_seq_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       oe_i,
   input logic       run_i,
   input logic       zc_i,
   input logic       speed_ok_i,
   input logic [2:0] hs_o,
   input logic [2:0] ls_o,
   input logic [2:0] mode_o,
   input logic [2:0] step_o,
   input logic       spin_o
);

   logic live_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) live_q <= 1'b0;
      else         live_q <= 1'b1;
   end

   // R2
   r2_oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !oe_i |-> (hs_o == 3'b000 && ls_o == 3'b000));

   // R7
   r7_no_shoot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((hs_o & ls_o) == 3'b000) && ($countones(hs_o) <= 1)
      && ($countones(ls_o) <= 1 || mode_o == 3'd6));

   // R7
   r7_step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_o >= 3'd1) && (step_o <= 3'd6));

   // R3
   r3_idle_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 3'd0) |-> (step_o == 3'd1));

   // R5
   r5_zc_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 3'd1 && oe_i && run_i && zc_i) |=> (mode_o == 3'd3 && step_o == 3'd2));

   // R10
   r10_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 3'd3 && run_i && speed_ok_i) |=> (mode_o == 3'd4));

   // R11
   r11_park_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i && mode_o >= 3'd1 && mode_o <= 3'd4) |=> (mode_o == 3'd5 && step_o == 3'd1));

   // R11
   r11_brake_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 3'd6 && oe_i) |-> (ls_o == 3'b111 && hs_o == 3'b000));

   // R12
   r12_spin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && $past(zc_i)) |-> (spin_o != $past(spin_o)));

endmodule

bind spindle_seq spindle_seq_chk u_chk (.*);

// File: tb/tb_spindle_seq.sv
module tb_spindle_seq;

   localparam int SPIN_W      = 4;
   localparam int ALIGN_DIV   = 4;
   localparam int ALIGN_TICKS = 64;
   localparam int MASK_CYC    = 5;
   localparam int BRK_W       = 3;
   localparam int PARK_UNIT   = 8;
   localparam int WIN         = 1 << SPIN_W;
   localparam int ALIGN_LEN   = ALIGN_DIV * ALIGN_TICKS;

   // {step, hs, ls} seen while walking with seq_inc from step 4
   localparam logic [8:0] WALK [7] = '{
      {3'd4, 3'b010, 3'b001},
      {3'd5, 3'b100, 3'b001},
      {3'd6, 3'b100, 3'b010},
      {3'd1, 3'b001, 3'b010},
      {3'd2, 3'b001, 3'b100},
      {3'd3, 3'b010, 3'b100},
      {3'd4, 3'b010, 3'b001}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             oe = 1'b0;
   logic             run = 1'b0;
   logic             inc = 1'b0;
   logic             zc = 1'b0;
   logic             spd = 1'b0;
   logic [BRK_W-1:0] bdly = '0;
   logic [2:0]       hs, ls, mode, step;
   logic             tri_s, spin;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   spindle_seq #(
      .SPIN_W(SPIN_W), .ALIGN_DIV(ALIGN_DIV), .ALIGN_TICKS(ALIGN_TICKS),
      .MASK_CYC(MASK_CYC), .BRK_W(BRK_W), .PARK_UNIT(PARK_UNIT)
   ) dut (
      .clk_i(clk), .rst_ni(rst_n), .oe_i(oe), .run_i(run), .seq_inc_i(inc),
      .zc_i(zc), .speed_ok_i(spd), .brk_dly_i(bdly), .hs_o(hs), .ls_o(ls),
      .tri_o(tri_s), .mode_o(mode), .step_o(step), .spin_o(spin)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      cyc(3);
      chk("R1 mode", mode, 0);
      chk("R1 step", step, 1);
      chk("R1 drivers", {hs, ls}, 0);
      chk("R1 tri", tri_s, 1);
      chk("R1 spin", spin, 0);
      rst_n = 1'b1;
      cyc(4);
      chk("R3 idle hold mode", mode, 0);
      chk("R3 idle hold step", step, 1);

      // run high with enable low: check window must not count
      run = 1'b1;
      cyc(1);
      chk("R3 enter check mode", mode, 1);
      chk("R3 enter check step", step, 2);
      cyc(40);
      chk("R4 window frozen without enable", mode, 1);
      chk("R2 drivers off enable low", {hs, ls}, 0);

      oe = 1'b1;
      cyc(WIN - 1);
      chk("R4 window not yet over", mode, 1);
      chk("R3 drivers off in check", {hs, ls}, 0);
      chk("R13 tri in check", tri_s, 1);
      cyc(1);
      chk("R4 align after window", mode, 2);
      chk("R6 align step", step, 2);
      chk("R7 step2 hs", hs, 3'b001);
      chk("R7 step2 ls", ls, 3'b100);
      chk("R13 tri while driving", tri_s, 0);
      cyc(ALIGN_LEN - 1);
      chk("R6 still aligning", mode, 2);
      cyc(1);
      chk("R6 start after align", mode, 3);
      chk("R6 double step", step, 4);

      // vector walk through the decode table, crossing the 6->1 wrap
      for (int i = 0; i < 7; i++) begin
         chk("R8 walk step", step, WALK[i][8:6]);
         chk("R7 walk hs", hs, WALK[i][5:3]);
         chk("R7 walk ls", ls, WALK[i][2:0]);
         if (i < 6) begin
            inc = 1'b1;
            cyc(1);
            inc = 1'b0;
         end
      end

      // zero-crossing mask delay, with a second crossing inside it
      zc = 1'b1;
      cyc(1);
      zc = 1'b0;
      chk("R12 spin toggled", spin, 1);
      cyc(1);
      zc = 1'b1;
      cyc(1);
      zc = 1'b0;
      cyc(2);
      chk("R9 before mask end", step, 4);
      cyc(1);
      chk("R9 after mask", step, 5);
      cyc(10);
      chk("R9 second crossing ignored", step, 5);
      chk("R12 spin toggled twice", spin, 0);

      spd = 1'b1;
      cyc(1);
      spd = 1'b0;
      chk("R10 run mode", mode, 4);

      oe = 1'b0;
      #1;
      chk("R2 enable low in run", {hs, ls}, 0);
      chk("R13 tri enable low", tri_s, 1);
      @(negedge clk);
      oe = 1'b1;
      #1;
      chk("R7 step5 hs", hs, 3'b100);
      @(negedge clk);

      // shutdown: park for (2+1)*PARK_UNIT cycles then brake
      bdly = 3'd2;
      run  = 1'b0;
      cyc(1);
      chk("R11 park mode", mode, 5);
      chk("R11 park step", step, 1);
      chk("R11 park drivers off", {hs, ls}, 0);
      cyc(3 * PARK_UNIT - 1);
      chk("R11 park length", mode, 5);
      cyc(1);
      chk("R11 brake mode", mode, 6);
      chk("R11 brake ls", ls, 3'b111);
      chk("R11 brake hs", hs, 3'b000);
      chk("R13 tri in brake", tri_s, 0);
      oe = 1'b0;
      #1;
      chk("R2 enable overrides brake", ls, 0);
      @(negedge clk);

      // restart while still spinning: crossing in window skips align
      run = 1'b1;
      cyc(1);
      chk("R3 check from brake", mode, 1);
      oe = 1'b1;
      cyc(2);
      zc = 1'b1;
      cyc(1);
      zc = 1'b0;
      chk("R5 skip to start", mode, 3);
      chk("R5 step kept", step, 2);
      cyc(MASK_CYC + 4);
      chk("R5 no stale advance", step, 2);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule